// File: doc/BRIEF.md
# Tile-Triggered Pattern Bank Latch

This block turns video-chip pattern fetches in the bottom 8 KiB of video address space into addresses in a CHR ROM that is organised as 4 KiB banks. Video address bit 12 splits that space into two halves. Each half has two candidate bank numbers, named A and B. The CPU-side register block supplies all four bank numbers. Each half also has a one-bit selector that picks A or B for that half. Software does not write the selectors. They change on their own when the video fetch stream reads one of two tile indices.

Pattern fetches arrive as an address together with a read strobe. The translated ROM address is produced combinationally in the same cycle. It is built from the selector values held before the fetch. A selector change caused by a fetch is registered on that fetch's clock edge, so the new selection first applies to the next access.

A second, side-effect-free peek port translates any address with the same selector state and never changes a selector. Addresses from 0x2000 upward belong to nametable logic. For those, both ports report no hit and drive an address of zero.

Top module: `chr_tile_latch`

## Requirements
- R1: For a translated address, half = bit 12. Half 0 uses bank_lo_a_i when its selector is 0 and bank_lo_b_i when it is 1. Half 1 uses bank_hi_a_i and bank_hi_b_i in the same way.
- R2: The translated address is the chosen bank number in bits BANK_W+11..12 and video address bits 11..0 in bits 11..0. chr_hit_o is 1.
- R3: A selector can change only on a clock edge where rd_i is 1, the address is below 0x2000, and address bit 3 is 1 (low nibble 8..15). Fetches with a low nibble of 0..7 never change a selector.
- R4: Tile index = address bits 11..4. On a qualifying fetch, tile 0xFD clears that half's selector to 0 and tile 0xFE sets it to 1. Every other tile leaves it unchanged.
- R5: The fetch that triggers a selector change is translated with the old selector value. The new value applies from the following cycle onward.
- R6: A fetch in one half never alters the other half's selector.
- R7: The peek port gives the same translation as the fetch port for the current selectors. Peek activity, and fetch-port activity with rd_i low, never changes a selector.
- R8: For addresses of 0x2000 and above, both ports output hit 0 and address 0, and a read there leaves both selectors unchanged.
- R9: While rst_ni is low, both selectors are 0. This holds asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vaddr_i | input | 14 | Video fetch address |
| rd_i | input | 1 | Fetch read strobe |
| bank_lo_a_i | input | BANK_W | Bank A, low half |
| bank_lo_b_i | input | BANK_W | Bank B, low half |
| bank_hi_a_i | input | BANK_W | Bank A, high half |
| bank_hi_b_i | input | BANK_W | Bank B, high half |
| chr_hit_o | output | 1 | Fetch address is in pattern space |
| chr_addr_o | output | BANK_W+12 | Translated fetch address |
| peek_addr_i | input | 14 | Peek address |
| peek_hit_o | output | 1 | Peek address is in pattern space |
| peek_chr_addr_o | output | BANK_W+12 | Translated peek address |

## Verification
Both translated addresses are combinational, so they are due in the same cycle as their inputs. A selector change is due one clock edge after its triggering fetch. The bench drives on the falling edge and samples both ports 2 ns later, before the next rising edge. It advances its own selector model only after that rising edge. As a result, every fetch check compares against the pre-edge selectors, and the next cycle's check sees the updated selectors. The peek port is aimed mostly at the opposite half, so any change in the neighbour's selector shows up at the ports.

// File: rtl/chr_tile_latch_pkg.sv
package chr_tile_latch_pkg;
  localparam int unsigned VADDR_W    = 14;
  localparam int unsigned OFS_W      = 12;
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned NUM_BANKS  = 2 * NUM_HALVES;
  localparam logic [7:0]  TILE_CLR   = 8'hFD;
  localparam logic [7:0]  TILE_SET   = 8'hFE;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2
  } latch_act_e;

  function automatic latch_act_e tile_action(logic [7:0] tile);
    if (tile == TILE_CLR)      return ACT_CLR;
    else if (tile == TILE_SET) return ACT_SET;
    else                       return ACT_HOLD;
  endfunction
endpackage

// File: rtl/chr_fetch_decode.sv
module chr_fetch_decode
  import chr_tile_latch_pkg::*;
(
  input  logic [VADDR_W-1:0]    vaddr_i,
  input  logic                  rd_i,
  output logic [NUM_HALVES-1:0] clr_o,
  output logic [NUM_HALVES-1:0] set_o
);
  logic       qual;
  logic       half;
  latch_act_e act;

  // only the second plane byte of a tile in pattern space qualifies
  assign qual = rd_i && !vaddr_i[VADDR_W-1] && vaddr_i[3];
  assign half = vaddr_i[OFS_W];
  assign act  = tile_action(vaddr_i[OFS_W-1:4]);

  always_comb begin
    clr_o = '0;
    set_o = '0;
    if (qual) begin
      clr_o[half] = (act == ACT_CLR);
      set_o[half] = (act == ACT_SET);
    end
  end
endmodule

// File: rtl/chr_half_latch.sv
module chr_half_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_o <= 1'b0;
    else if (clr_i) sel_o <= 1'b0;
    else if (set_i) sel_o <= 1'b1;
  end
endmodule

// File: rtl/chr_bank_xlate.sv
module chr_bank_xlate
  import chr_tile_latch_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  localparam int unsigned CHR_W = BANK_W + OFS_W
) (
  input  logic [VADDR_W-1:0]                addr_i,
  input  logic [NUM_HALVES-1:0]             sel_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  banks_i,
  output logic                              hit_o,
  output logic [CHR_W-1:0]                  chr_addr_o
);
  logic       half;
  logic [1:0] reg_idx;

  assign half    = addr_i[OFS_W];
  assign reg_idx = {half, sel_i[half]};
  assign hit_o   = !addr_i[VADDR_W-1];

  always_comb begin
    if (hit_o) chr_addr_o = {banks_i[reg_idx], addr_i[OFS_W-1:0]};
    else       chr_addr_o = '0;
  end
endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch
  import chr_tile_latch_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  localparam int unsigned CHR_W = BANK_W + OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VADDR_W-1:0] vaddr_i,
  input  logic               rd_i,
  input  logic [BANK_W-1:0]  bank_lo_a_i,
  input  logic [BANK_W-1:0]  bank_lo_b_i,
  input  logic [BANK_W-1:0]  bank_hi_a_i,
  input  logic [BANK_W-1:0]  bank_hi_b_i,
  output logic               chr_hit_o,
  output logic [CHR_W-1:0]   chr_addr_o,
  input  logic [VADDR_W-1:0] peek_addr_i,
  output logic               peek_hit_o,
  output logic [CHR_W-1:0]   peek_chr_addr_o
);
  logic [NUM_HALVES-1:0]            clr, set, sel_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;

  // index = half*2 + selector
  assign banks = {bank_hi_b_i, bank_hi_a_i, bank_lo_b_i, bank_lo_a_i};

  chr_fetch_decode u_dec (
    .vaddr_i (vaddr_i),
    .rd_i    (rd_i),
    .clr_o   (clr),
    .set_o   (set)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    chr_half_latch u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[h]),
      .set_i  (set[h]),
      .sel_o  (sel_q[h])
    );
  end

  chr_bank_xlate #(.BANK_W(BANK_W)) u_fetch_xl (
    .addr_i     (vaddr_i),
    .sel_i      (sel_q),
    .banks_i    (banks),
    .hit_o      (chr_hit_o),
    .chr_addr_o (chr_addr_o)
  );

  chr_bank_xlate #(.BANK_W(BANK_W)) u_peek_xl (
    .addr_i     (peek_addr_i),
    .sel_i      (sel_q),
    .banks_i    (banks),
    .hit_o      (peek_hit_o),
    .chr_addr_o (peek_chr_addr_o)
  );
endmodule

// File: rtl/chr_tile_latch_chk.sv
module chr_tile_latch_chk
  import chr_tile_latch_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  localparam int unsigned CHR_W = BANK_W + OFS_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [VADDR_W-1:0]    vaddr_i,
  input logic                  rd_i,
  input logic                  chr_hit_o,
  input logic [CHR_W-1:0]      chr_addr_o,
  input logic [VADDR_W-1:0]    peek_addr_i,
  input logic [CHR_W-1:0]      peek_chr_addr_o,
  input logic [NUM_HALVES-1:0] sel_q
);
  logic qual;
  assign qual = rd_i && !vaddr_i[VADDR_W-1] && vaddr_i[3];

  a_r3_no_upd_unqualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> $stable(sel_q));

  a_r4_clear_on_fd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual && vaddr_i[11:4] == TILE_CLR) |=> !sel_q[$past(vaddr_i[OFS_W])]);

  a_r4_set_on_fe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual && vaddr_i[11:4] == TILE_SET) |=> sel_q[$past(vaddr_i[OFS_W])]);

  a_r6_low_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vaddr_i[OFS_W] |=> $stable(sel_q[1]));

  a_r6_high_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_i[OFS_W] |=> $stable(sel_q[0]));

  a_r7_peek_matches_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_addr_i == vaddr_i) |-> (peek_chr_addr_o == chr_addr_o));

  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_i[VADDR_W-1] |-> (!chr_hit_o && chr_addr_o == '0));

  a_r2_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_hit_o |-> (chr_addr_o[OFS_W-1:0] == vaddr_i[OFS_W-1:0]));
endmodule

bind chr_tile_latch chr_tile_latch_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .vaddr_i         (vaddr_i),
  .rd_i            (rd_i),
  .chr_hit_o       (chr_hit_o),
  .chr_addr_o      (chr_addr_o),
  .peek_addr_i     (peek_addr_i),
  .peek_chr_addr_o (peek_chr_addr_o),
  .sel_q           (sel_q)
);

// File: tb/chr_tile_latch_tb.sv
module chr_tile_latch_tb;
  localparam int unsigned BANK_W = 5;
  localparam int unsigned CHR_W  = BANK_W + 12;
  localparam logic [BANK_W-1:0] LA = 5'd3, LB = 5'd9, HA = 5'd17, HB = 5'd30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [13:0]       vaddr = '0;
  logic              rd = 1'b0;
  logic [13:0]       paddr = '0;
  logic              hit, phit;
  logic [CHR_W-1:0]  caddr, paddr_o;
  logic [1:0]        lat = 2'b00;
  int                n_run = 0, n_fail = 0;
  logic              done = 1'b0;

  always #10 clk = ~clk;

  chr_tile_latch #(.BANK_W(BANK_W)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .vaddr_i (vaddr), .rd_i (rd),
    .bank_lo_a_i (LA), .bank_lo_b_i (LB), .bank_hi_a_i (HA), .bank_hi_b_i (HB),
    .chr_hit_o (hit), .chr_addr_o (caddr),
    .peek_addr_i (paddr), .peek_hit_o (phit), .peek_chr_addr_o (paddr_o)
  );

  function automatic logic [CHR_W-1:0] exp_addr(logic [13:0] a);
    logic [BANK_W-1:0] b;
    if (a[13]) return '0;
    b = a[12] ? (lat[1] ? HB : HA) : (lat[0] ? LB : LA);
    return {b, a[11:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [13:0] a, logic r, logic [13:0] pa, string req);
    @(negedge clk);
    vaddr = a; rd = r; paddr = pa;
    #2;
    check(req, 32'(hit), 32'(!a[13]));
    check(req, 32'(caddr), 32'(exp_addr(a)));
    check("R6/R7 peek", 32'(phit), 32'(!pa[13]));
    check("R6/R7 peek", 32'(paddr_o), 32'(exp_addr(pa)));
    @(posedge clk);
    #1;
    if (r && !a[13] && a[3]) begin
      if (a[11:4] == 8'hFD) lat[a[12]] = 1'b0;
      else if (a[11:4] == 8'hFE) lat[a[12]] = 1'b1;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] tiles [8];
    tiles = '{8'hFE, 8'hFD, 8'hFE, 8'h00, 8'hFC, 8'hFF, 8'hFE, 8'hFD};
    // R9: reset state, checked during reset
    #5;
    paddr = 14'h0123; #1;
    check("R9 low", 32'(paddr_o), 32'({LA, 12'h123}));
    paddr = 14'h1456; #1;
    check("R9 high", 32'(paddr_o), 32'({HA, 12'h456}));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3/R4/R5: every low nibble across magic and plain tiles
    for (int h = 0; h < 2; h++)
      for (int t = 0; t < 8; t++)
        for (int n = 0; n < 16; n++)
          step({1'b0, 1'(h), tiles[t], 4'(n)}, 1'b1,
               {1'b0, 1'(h ^ 1), 8'h40, 4'(n)}, "R3/R4/R5");

    // R1/R4: all tile indices, second plane byte, both halves
    for (int h = 0; h < 2; h++)
      for (int t = 0; t < 256; t++)
        step({1'b0, 1'(h), 8'(t), 4'h8}, 1'b1,
             {1'b0, 1'(h ^ 1), 8'(255 - t), 4'h3}, "R1/R4");

    // R2: offsets across pattern space, rd low
    for (int a = 0; a < 14'h2000; a += 14'h0A3)
      step(14'(a), 1'b0, 14'(a ^ 14'h1000), "R2");

    // R7: magic tiles with rd low must not change the selectors
    step(14'h0FE8, 1'b1, 14'h1FE8, "R7 setup");
    step(14'h1FE8, 1'b1, 14'h0FD8, "R7 setup");
    step(14'h0FD8, 1'b0, 14'h0FD8, "R7");
    step(14'h1FDF, 1'b0, 14'h1FDF, "R7");
    step(14'h0010, 1'b0, 14'h1010, "R7 after");

    // R8: pattern-looking reads above 0x2000
    step(14'h2FD8, 1'b1, 14'h3FE8, "R8");
    step(14'h3FDF, 1'b1, 14'h2000, "R8");
    step(14'h2FE8, 1'b1, 14'h0FD8, "R8");
    step(14'h0000, 1'b0, 14'h1000, "R8 after");

    // R5: trigger cycle uses old, next cycle new
    step(14'h0FD9, 1'b1, 14'h0FD9, "R5");
    step(14'h0ABC, 1'b1, 14'h1ABC, "R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule